// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is an up-counter built from a chain of identical 4-bit stages. All of its state changes happen on the rising clock edge, including clearing and loading. Each stage has a clear input, a load input, two count enables and a terminal-count output.

The first enable (`en_p`) only allows or stops counting. The second enable (`en_t`) also gates the terminal-count output. The top wrapper feeds each stage's terminal count into the `en_t` of the stage above it. The whole chain therefore behaves as one counter of 4×`STAGES` bits, and the terminal count of the last stage is brought out for further cascading.

The cycle length can be shortened outside the block: decode a chosen count and drive `clr_n` low from that decode. The counter then returns to zero on the following edge.

Top module: `cnt_chain`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes 0 after that edge, whatever `load_n`, `en_p`, `en_t` and `din` are.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` after that edge, whatever the two enables are.
- R3: When `clr_n`, `load_n`, `en_p` and `en_t` are all high at a rising edge, `q` increases by one, modulo 2^(4×`STAGES`). The all-ones value wraps to 0.
- R4: When `clr_n` and `load_n` are high and either enable is low, `q` keeps its value across the edge.
- R5: `tc_out` is combinational. It is 1 exactly when `q` is all ones and `en_t` is 1, and `en_p` has no effect on it.
- R6: A 4-bit stage above the lowest one changes on a counting edge only when every stage below it holds all ones, so the chain counts with no skipped or repeated values.
- R7: `tc_out` follows the present registered count even while a clear or load is applied, so it is 1 before the edge if `q` is all ones and `en_t` is 1.
- R8: If `clr_n` is driven low from a decode of count 9, the counter runs through 0..9 repeatedly and returns to 0 on the edge after 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable that does not affect terminal count |
| en_t | input | 1 | Count enable that also gates terminal count |
| din | input | 4×STAGES | Parallel load data |
| q | output | 4×STAGES | Present count |
| tc_out | output | 1 | Terminal count of the last stage |

## Verification
Clear, load and count each show on `q` exactly one edge after the inputs that select them. The bench drives inputs at the falling edge, lets the rising edge act, and compares `q` with its integer model at the next falling edge. `tc_out` has no register in its path. It is therefore checked 1 ns after the inputs change and before the rising edge, which is how the R7 case of all ones with a pending load or clear is caught. In the modulo-10 phase the bench forms `clr_n` from the `q` it sees at the falling edge, so the clear takes effect at the next rising edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);

  // Fixed priority: clear, then load, then count, else hold.
  always_comb begin
    if (!clr_n)            op = OP_CLR;
    else if (!load_n)      op = OP_LOAD;
    else if (en_p && en_t) op = OP_INC;
    else                   op = OP_HOLD;
  end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  cnt_op_e      op;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_en;

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  // Next-state process
  always_comb begin
    q_nxt = q_r;
    case (op)
      OP_CLR:  q_nxt = '0;
      OP_LOAD: q_nxt = d;
      OP_INC:  q_nxt = q_r + ONE;
      default: q_nxt = q_r;
    endcase
  end

  assign q_en = (op != OP_HOLD);

  // Register process with explicit clock enable
  always_ff @(posedge clk) begin
    if (q_en) q_r <= q_nxt;
  end

  assign q  = q_r;
  assign tc = en_t & (q_r == ALL_ONES);

  // Assertion arming: valid once a clear edge has been seen
  logic armed;
  always_ff @(posedge clk) begin
    if (!clr_n) armed <= 1'b1;
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (q == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> (q == $past(d)));

  a_r3_increment: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && en_p && en_t) |=> (q == $past(q) + ONE));

  a_r4_hold: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic                      load_n,
  input  logic                      en_p,
  input  logic                      en_t,
  input  logic [NIB_W*STAGES-1:0]   din,
  output logic [NIB_W*STAGES-1:0]   q,
  output logic                      tc_out
);

  localparam int unsigned TW = NIB_W * STAGES;

  // et_link[k] feeds stage k; et_link[k+1] is that stage's terminal count
  logic [STAGES:0] et_link;

  assign et_link[0] = en_t;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cnt_stage #(.W(NIB_W)) u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (et_link[k]),
      .d      (din[k*NIB_W +: NIB_W]),
      .q      (q[k*NIB_W +: NIB_W]),
      .tc     (et_link[k+1])
    );
  end

  assign tc_out = et_link[STAGES];

  // Assertion arming
  logic armed;
  always_ff @(posedge clk) begin
    if (!clr_n) armed <= 1'b1;
  end

  a_r5_tc_full: assert property (@(posedge clk) disable iff (!armed)
    tc_out |-> (en_t && (q == {TW{1'b1}})));

  for (genvar k = 1; k < STAGES; k++) begin : g_ripple_chk
    a_r6_upper_waits: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !et_link[k]) |=> $stable(q[k*NIB_W +: NIB_W]));
  end

endmodule

// File: tb/tb_cnt_chain.sv
`timescale 1ns/1ps
module tb_cnt_chain;

  localparam int STAGES = 2;
  localparam int W      = 4 * STAGES;
  localparam int MODV   = 1 << W;
  localparam int MAXV   = MODV - 1;

  logic         clk = 1'b0;
  logic         clr_n, load_n, en_p, en_t;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         tc_out;

  int n_chk  = 0;
  int n_fail = 0;
  int ref_q  = 0;

  always #10 clk = ~clk;

  cnt_chain #(.STAGES(STAGES)) dut (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .din    (din),
    .q      (q),
    .tc_out (tc_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at falling edge, check tc before the rising edge,
  // update the model at the rising edge, check q at the next falling edge.
  task automatic cyc(input bit c, input bit l, input int d, input bit p, input bit t);
    bit exp_tc;
    clr_n = c; load_n = l; din = W'(d); en_p = p; en_t = t;
    #1;
    exp_tc = (ref_q == MAXV) && t;
    chk(tc_out === exp_tc, (!c || !l) ? "R7 tc under clear/load" : "R5 tc",
        int'(tc_out), int'(exp_tc));
    @(posedge clk);
    if (!c)          ref_q = 0;
    else if (!l)     ref_q = d & MAXV;
    else if (p && t) ref_q = (ref_q + 1) % MODV;
    @(negedge clk);
    for (int s = 0; s < STAGES; s++) begin
      int a, e;
      a = int'(q[s*4 +: 4]);
      e = (ref_q >> (4*s)) & 15;
      chk(a == e, !c ? "R1 clear" : !l ? "R2 load" :
                  (p && t) ? "R3/R6 count stage" : "R4 hold", a, e);
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clr_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
    @(negedge clk);
    // R1: clear while load and both enables are active
    cyc(0, 0, 8'hA5, 1, 1);
    chk(q == 0, "R1 reset state", int'(q), 0);
    // R2: load ignores enables being low
    cyc(1, 0, 8'h3C, 0, 0);
    // R4: each enable low alone holds
    cyc(1, 1, 0, 0, 1);
    cyc(1, 1, 0, 1, 0);
    // R3/R6: count across nibble boundary and through wrap
    cyc(1, 0, 8'hF8, 1, 1);
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 1, 1);
    chk(q == 8'h02, "R3 wrap", int'(q), 8'h02);
    // R5: all ones, en_p low does not drop tc
    cyc(1, 0, MAXV, 0, 0);
    cyc(1, 1, 0, 0, 1);
    chk(tc_out === 1'b1, "R5 tc with en_p low", int'(tc_out), 1);
    cyc(1, 1, 0, 1, 0);
    // R7: at all ones, load and clear pending keep tc high before the edge
    cyc(1, 0, 8'h11, 0, 1);
    cyc(1, 0, MAXV, 1, 1);
    cyc(0, 1, 0, 1, 1);
    // R6: lower stage at 0xF with en_t high but en_p low: upper stage holds
    cyc(1, 0, 8'h2F, 1, 1);
    cyc(1, 1, 0, 0, 1);
    chk(q == 8'h2F, "R6 upper holds", int'(q), 8'h2F);
    cyc(1, 1, 0, 1, 1);
    chk(q == 8'h30, "R6 upper steps", int'(q), 8'h30);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      bit c, l, p, t;
      c = ($urandom_range(0, 99) >= 3);
      l = ($urandom_range(0, 99) >= 6);
      p = ($urandom_range(0, 99) >= 15);
      t = ($urandom_range(0, 99) >= 15);
      cyc(c, l, int'($urandom_range(0, MAXV)), p, t);
    end
    // R8: modulo-10 by clearing from a decode of 9
    cyc(0, 1, 0, 1, 1);
    for (int i = 0; i < 45; i++) begin
      bit was9;
      was9 = (q == 9);
      cyc(!was9, 1, 0, 1, 1);
      chk(q <= 9, "R8 range", int'(q), 9);
      if (was9) chk(q == 0, "R8 return to zero", int'(q), 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule